// File: doc/BRIEF.md
# Interrupt Coalescing Controller

This block sits between four storage ports and one host interrupt line. Each port reports finished commands as single-cycle completion pulses and also presents a raw level "done" bit. The controller counts completions and holds back a single coalesced event until one of two limits is reached. The first limit is a programmed number of completions. The second is a programmed number of clock cycles counted from the first completion that is still waiting. Whichever limit is reached first raises the event. The counter and the timer then start over.

Software uses a small register port. Writes take effect on the clock edge, and reads are combinational. Through this port software sets the two thresholds, either directly in clocks or in microseconds that the block converts into clocks. It also reads and clears the cause word and programs an enable mask. In the effective mask, the coalesced enable and the per-port done enables exclude each other. The interrupt output is the OR of the cause bits that are enabled. A sequencer with three states follows the pending completions:

- **ST_OFF**: coalescing is disabled.
- **ST_IDLE**: coalescing is enabled and no completion is waiting.
- **ST_TIMING**: at least one completion is waiting and the timer is running.

Its transitions are:

| Transition | From | To | Taken when |
|---|---|---|---|
| ENABLE | ST_OFF | ST_IDLE | both thresholds are nonzero |
| DISABLE | ST_IDLE or ST_TIMING | ST_OFF | either threshold is zero |
| ARM | ST_IDLE | ST_TIMING | a completion arrives and the count threshold is not yet met |
| FIRE | ST_IDLE or ST_TIMING | ST_IDLE | a threshold is met; the event is raised and the counter and timer are cleared |

Top module: `coal_ctrl`

## Requirements
- R1: After reset, every register reads 0, the coalesced cause bit is 0 and `irq` is 0.
- R2: The count threshold lives at address 0 and uses bits [7:0]. When the number of completions reaches or passes the threshold, cause bit 4 is set, and it is visible right after the clock edge that sampled the pulse which met the threshold.
- R3: Pulses from several ports in the same cycle each add one to the count. The count saturates at 255 and never wraps.
- R4: The time threshold T lives at address 1 and uses bits [23:0]. If the count threshold has not been met first, cause bit 4 is set at the T-th clock edge after the edge that sampled the first waiting completion.
- R5: A write to address 2 with value U loads the time threshold with min(U*150, 2^24-1). Address 2 reads as 0.
- R6: When either threshold is 0, no coalesced event is raised. Completions that arrive while disabled are not counted later, and bit 4 of the effective mask reads 0.
- R7: The cause word lives at address 3. Bit 4 is the sticky coalesced event. A write with bit 4 = 0 clears it and a write with bit 4 = 1 keeps it. If a new event and a clear happen in the same cycle, the event wins. Bit 2n+1 shows the live `port_done[n]`, and all other bits read 0.
- R8: The enable mask lives at address 4 and stores only bits 1, 3, 4, 5 and 7. The effective mask at address 5 is built from it in two steps. First, its bit 4 is the stored bit 4 ANDed with both thresholds being nonzero. Second, whenever the effective bit 4 is 1, bits 1, 3, 5 and 7 are forced to 0.
- R9: `irq` is the OR of the cause word ANDed with the effective mask, in the same cycle. It stays high until the enabled cause bits are cleared.
- R10: Raising the event clears the counter and the timer. The timer then stays idle, so no further event occurs until a new completion arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| cmpl_pulse | input | 4 | One-cycle completion pulse per port |
| port_done | input | 4 | Raw per-port done level |
| irq | output | 1 | Host interrupt |

## Verification
Register writes and the usec conversion can be read back in the cycle that follows the write edge. A count-limited event appears right after the edge that sampled the completion which met the threshold. A time-limited event appears exactly T edges after the first completion's edge, so the bench checks the cause bit both one cycle before and at that edge. `irq` and the live done bits follow their inputs in the same cycle. The driver pushes each expectation into the queue at a falling edge. The monitor compares it 2 ns later, with the stimulus for that cycle already settled and before the next rising edge.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int ADDR_W   = 3;
    localparam int COAL_BIT = 4;

    localparam logic [ADDR_W-1:0] A_CNT_THR  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TIME_THR = 3'd1;
    localparam logic [ADDR_W-1:0] A_USEC     = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAUSE    = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd4;
    localparam logic [ADDR_W-1:0] A_EFF      = 3'd5;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_TIMING = 2'd2
    } coal_state_e;

    // bit 2n+1 set for each port n
    function automatic logic [31:0] done_bits(int ports);
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < ports; n++) begin
            m[2*n+1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/coal_regs.sv
module coal_regs
    import coal_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 8,
    parameter int TIME_W     = 24,
    parameter int MASK_W     = 8,
    parameter int CLK_PER_US = 150,
    parameter logic [MASK_W-1:0] MASK_VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_thr,
    output logic [TIME_W-1:0] time_thr,
    output logic [MASK_W-1:0] mask_q,
    output logic              coal_on
);

    localparam int MULT_W = $clog2(CLK_PER_US + 1);
    localparam int PROD_W = DATA_W + MULT_W;

    logic [PROD_W-1:0] prod;
    logic [TIME_W-1:0] usec_clk;
    logic              too_big;

    assign prod    = PROD_W'(wr_data) * PROD_W'(CLK_PER_US);
    assign too_big = |prod[PROD_W-1:TIME_W];
    assign usec_clk = too_big ? {TIME_W{1'b1}} : prod[TIME_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_thr  <= '0;
            time_thr <= '0;
            mask_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CNT_THR:  cnt_thr  <= wr_data[CNT_W-1:0];
                A_TIME_THR: time_thr <= wr_data[TIME_W-1:0];
                A_USEC:     time_thr <= usec_clk;
                A_MASK:     mask_q   <= wr_data[MASK_W-1:0] & MASK_VALID;
                default:    ;
            endcase
        end
    end

    assign coal_on = (|cnt_thr) && (|time_thr);

endmodule

// File: rtl/coal_engine.sv
module coal_engine
    import coal_pkg::*;
#(
    parameter int PORTS  = 4,
    parameter int CNT_W  = 8,
    parameter int TIME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORTS-1:0]  cmpl,
    input  logic [CNT_W-1:0]  cnt_thr,
    input  logic [TIME_W-1:0] time_thr,
    input  logic              coal_on,
    output logic              fire,
    output coal_state_e       st,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [TIME_W-1:0] tmr_q
);

    localparam int INC_W = $clog2(PORTS + 1);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    coal_state_e       st_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [TIME_W-1:0] tmr_n;
    logic [INC_W-1:0]  inc;
    logic [CNT_W:0]    sum_w;
    logic [CNT_W-1:0]  sat;
    logic              any_cmpl;
    logic              cnt_hit;
    logic              time_hit;

    always_comb begin
        inc = '0;
        for (int i = 0; i < PORTS; i++) begin
            inc = inc + INC_W'(cmpl[i]);
        end
    end

    assign any_cmpl = |cmpl;
    assign sum_w    = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    assign sat      = (sum_w > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum_w[CNT_W-1:0];
    assign cnt_hit  = any_cmpl && (sat >= cnt_thr);
    assign time_hit = (tmr_q >= time_thr);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_OFF;
            cnt_q <= '0;
            tmr_q <= '0;
        end else begin
            st    <= st_n;
            cnt_q <= cnt_n;
            tmr_q <= tmr_n;
        end
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (st)
            ST_OFF:    fire = 1'b0;
            ST_IDLE:   fire = coal_on && cnt_hit;
            ST_TIMING: fire = coal_on && (cnt_hit || time_hit);
            default:   fire = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt_q;
        tmr_n = tmr_q;
        unique case (st)
            ST_OFF: begin
                cnt_n = '0;
                tmr_n = '0;
                if (coal_on) begin
                    st_n = ST_IDLE;                 // ENABLE
                end
            end
            ST_IDLE: begin
                if (!coal_on) begin
                    st_n  = ST_OFF;                 // DISABLE
                    cnt_n = '0;
                    tmr_n = '0;
                end else if (fire) begin
                    cnt_n = '0;                     // FIRE
                    tmr_n = '0;
                end else if (any_cmpl) begin
                    st_n  = ST_TIMING;              // ARM
                    cnt_n = sat;
                    tmr_n = TIME_W'(1);
                end
            end
            ST_TIMING: begin
                if (!coal_on) begin
                    st_n  = ST_OFF;                 // DISABLE
                    cnt_n = '0;
                    tmr_n = '0;
                end else if (fire) begin
                    st_n  = ST_IDLE;                // FIRE
                    cnt_n = '0;
                    tmr_n = '0;
                end else begin
                    cnt_n = sat;
                    tmr_n = tmr_q + TIME_W'(1);
                end
            end
            default: begin
                st_n  = ST_OFF;
                cnt_n = '0;
                tmr_n = '0;
            end
        endcase
    end

endmodule

// File: rtl/coal_irq.sv
module coal_irq
    import coal_pkg::*;
#(
    parameter int PORTS  = 4,
    parameter int MASK_W = 8,
    parameter logic [MASK_W-1:0] DONE_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              clr_req,
    input  logic [PORTS-1:0]  port_done,
    input  logic [MASK_W-1:0] mask_q,
    input  logic              coal_on,
    output logic              cause_coal,
    output logic [MASK_W-1:0] cause_vec,
    output logic [MASK_W-1:0] eff_mask,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_coal <= 1'b0;
        end else if (fire) begin
            cause_coal <= 1'b1;
        end else if (clr_req) begin
            cause_coal <= 1'b0;
        end
    end

    always_comb begin
        cause_vec = '0;
        for (int n = 0; n < PORTS; n++) begin
            cause_vec[2*n+1] = port_done[n];
        end
        cause_vec[COAL_BIT] = cause_coal;
    end

    always_comb begin
        eff_mask           = mask_q;
        eff_mask[COAL_BIT] = mask_q[COAL_BIT] & coal_on;
        if (eff_mask[COAL_BIT]) begin
            eff_mask = eff_mask & ~DONE_MASK;
        end
    end

    assign irq = |(cause_vec & eff_mask);

endmodule

// File: rtl/coal_ctrl.sv
module coal_ctrl
    import coal_pkg::*;
#(
    parameter int PORTS      = 4,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 8,
    parameter int TIME_W     = 24,
    parameter int CLK_PER_US = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PORTS-1:0]  cmpl_pulse,
    input  logic [PORTS-1:0]  port_done,
    output logic              irq
);

    localparam int MASK_W = 2 * PORTS;
    localparam logic [MASK_W-1:0] DONE_MASK  = MASK_W'(done_bits(PORTS));
    localparam logic [MASK_W-1:0] MASK_VALID = DONE_MASK | (MASK_W'(1) << COAL_BIT);

    logic [CNT_W-1:0]  cnt_thr;
    logic [TIME_W-1:0] time_thr;
    logic [MASK_W-1:0] mask_q;
    logic              coal_on;
    logic              fire;
    coal_state_e       st;
    logic [CNT_W-1:0]  cnt_q;
    logic [TIME_W-1:0] tmr_q;
    logic              clr_req;
    logic              cause_coal;
    logic [MASK_W-1:0] cause_vec;
    logic [MASK_W-1:0] eff_mask;

    coal_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .TIME_W(TIME_W),
        .MASK_W(MASK_W), .CLK_PER_US(CLK_PER_US), .MASK_VALID(MASK_VALID)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_thr(cnt_thr), .time_thr(time_thr),
        .mask_q(mask_q), .coal_on(coal_on)
    );

    coal_engine #(
        .PORTS(PORTS), .CNT_W(CNT_W), .TIME_W(TIME_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .cmpl(cmpl_pulse), .cnt_thr(cnt_thr),
        .time_thr(time_thr), .coal_on(coal_on), .fire(fire), .st(st),
        .cnt_q(cnt_q), .tmr_q(tmr_q)
    );

    assign clr_req = wr_en && (wr_addr == A_CAUSE) && !wr_data[COAL_BIT];

    coal_irq #(
        .PORTS(PORTS), .MASK_W(MASK_W), .DONE_MASK(DONE_MASK)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr_req(clr_req),
        .port_done(port_done), .mask_q(mask_q), .coal_on(coal_on),
        .cause_coal(cause_coal), .cause_vec(cause_vec),
        .eff_mask(eff_mask), .irq(irq)
    );

    always_comb begin
        case (rd_addr)
            A_CNT_THR:  rd_data = DATA_W'(cnt_thr);
            A_TIME_THR: rd_data = DATA_W'(time_thr);
            A_CAUSE:    rd_data = DATA_W'(cause_vec);
            A_MASK:     rd_data = DATA_W'(mask_q);
            A_EFF:      rd_data = DATA_W'(eff_mask);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/coal_ctrl_chk.sv
module coal_ctrl_chk
    import coal_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 24,
    parameter int MASK_W = 8,
    parameter logic [MASK_W-1:0] DONE_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_keep,
    input logic [CNT_W-1:0]  cnt_thr,
    input logic [TIME_W-1:0] time_thr,
    input logic [MASK_W-1:0] eff_mask,
    input logic              cause_coal,
    input logic              fire,
    input coal_state_e       st,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [TIME_W-1:0] tmr_q
);

    // R8
    excl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_mask[COAL_BIT] |-> ((eff_mask & DONE_MASK) == '0));

    // R6
    off_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_thr == '0) || (time_thr == '0)) |-> !fire);

    // R6
    off_eff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_thr == '0) || (time_thr == '0)) |-> !eff_mask[COAL_BIT]);

    // R7
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_coal && !(wr_en && (wr_addr == A_CAUSE) && !wr_keep)) |=> cause_coal);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cause_coal);

    // R10
    fire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((cnt_q == '0) && (tmr_q == '0)));

    // R10
    idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (tmr_q == '0));

endmodule

bind coal_ctrl coal_ctrl_chk #(
    .CNT_W(CNT_W), .TIME_W(TIME_W), .MASK_W(MASK_W), .DONE_MASK(DONE_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_keep(wr_data[COAL_BIT]), .cnt_thr(cnt_thr), .time_thr(time_thr),
    .eff_mask(eff_mask), .cause_coal(cause_coal), .fire(fire), .st(st),
    .cnt_q(cnt_q), .tmr_q(tmr_q)
);

// File: tb/sim_coal_ctrl.sv
module sim_coal_ctrl;
    import coal_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        bit          is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic [3:0]  cmpl_pulse;
    logic [3:0]  port_done;
    logic        irq;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coal_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmpl_pulse(cmpl_pulse), .port_done(port_done), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hold(input logic [3:0] m, input int n);
        @(negedge clk);
        cmpl_pulse = m;
        repeat (n) @(negedge clk);
        cmpl_pulse = '0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] v, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.addr = a; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_irq(input logic v, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, v}; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor
    initial begin
        item_t it;
        logic [31:0] got;
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                it = q.pop_front();
                if (!it.is_irq) begin
                    rd_addr = it.addr;
                    #1;
                    got = rd_data;
                end else begin
                    #1;
                    got = {31'b0, irq};
                end
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s addr=%0d actual=%h expected=%h", it.tag,
                             it.is_irq ? "irq" : "reg", it.addr, got, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; cmpl_pulse = '0; port_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_rd(A_CNT_THR, 0, "R1"); exp_rd(A_TIME_THR, 0, "R1"); exp_rd(A_CAUSE, 0, "R1");
        tick(1);
        exp_rd(A_MASK, 0, "R1"); exp_rd(A_EFF, 0, "R1"); exp_irq(1'b0, "R1");

        wr(A_CNT_THR, 3); wr(A_TIME_THR, 1000); wr(A_MASK, 32'h10);
        exp_rd(A_CNT_THR, 3, "R2"); exp_rd(A_TIME_THR, 1000, "R4");
        tick(1);
        exp_rd(A_MASK, 32'h10, "R8"); exp_rd(A_EFF, 32'h10, "R8");

        // count threshold with multi-port pulses
        hold(4'b0001, 1);
        exp_rd(A_CAUSE, 0, "R2");
        hold(4'b0011, 1);
        exp_rd(A_CAUSE, 32'h10, "R3"); exp_irq(1'b1, "R2");
        tick(5);
        exp_rd(A_CAUSE, 32'h10, "R9"); exp_irq(1'b1, "R9");
        wr(A_CAUSE, 32'hFFFF_FFFF);
        exp_rd(A_CAUSE, 32'h10, "R7");
        wr(A_CAUSE, 0);
        exp_rd(A_CAUSE, 0, "R7"); exp_irq(1'b0, "R9");

        // counter restarts after event
        hold(4'b0001, 1); hold(4'b0001, 1);
        exp_rd(A_CAUSE, 0, "R10");
        hold(4'b0001, 1);
        exp_rd(A_CAUSE, 32'h10, "R10");
        wr(A_CAUSE, 0);

        // time threshold
        wr(A_TIME_THR, 20);
        hold(4'b0001, 1);
        tick(19);
        exp_rd(A_CAUSE, 0, "R4");
        tick(1);
        exp_rd(A_CAUSE, 32'h10, "R4");
        wr(A_CAUSE, 0);
        tick(40);
        exp_rd(A_CAUSE, 0, "R10");

        // saturation
        wr(A_CNT_THR, 255); wr(A_TIME_THR, 32'hFF_FFFF);
        hold(4'hF, 63);
        exp_rd(A_CAUSE, 0, "R3");
        hold(4'hF, 1);
        exp_rd(A_CAUSE, 32'h10, "R3");
        wr(A_CAUSE, 0);

        // usec conversion
        wr(A_USEC, 100);
        exp_rd(A_TIME_THR, 15000, "R5");
        wr(A_USEC, 200000);
        exp_rd(A_TIME_THR, 32'hFF_FFFF, "R5");
        wr(A_USEC, 111848);
        exp_rd(A_TIME_THR, 16777200, "R5"); exp_rd(A_USEC, 0, "R5");

        // disable by zero threshold
        wr(A_CNT_THR, 0);
        exp_rd(A_EFF, 0, "R6");
        hold(4'hF, 1); hold(4'hF, 1);
        exp_rd(A_CAUSE, 0, "R6");
        wr(A_MASK, 32'hFFFF_FFFF);
        exp_rd(A_MASK, 32'hBA, "R8"); exp_rd(A_EFF, 32'hAA, "R8");
        wr(A_CNT_THR, 2);
        exp_rd(A_EFF, 32'h10, "R8");
        hold(4'b0001, 1);
        exp_rd(A_CAUSE, 0, "R6");
        hold(4'b0001, 1);
        exp_rd(A_CAUSE, 32'h10, "R2"); exp_irq(1'b1, "R9");
        wr(A_CAUSE, 0);

        // live done bits and mask exclusion
        @(negedge clk);
        port_done = 4'b0101;
        exp_rd(A_CAUSE, 32'h22, "R7"); exp_irq(1'b0, "R8");
        wr(A_CNT_THR, 0);
        exp_rd(A_EFF, 32'hAA, "R8"); exp_irq(1'b1, "R9");
        @(negedge clk);
        port_done = 4'b0000;
        exp_irq(1'b0, "R9");

        // event wins over same-cycle clear
        wr(A_CNT_THR, 1);
        tick(1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CAUSE; wr_data = 0; cmpl_pulse = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; cmpl_pulse = '0;
        exp_rd(A_CAUSE, 32'h10, "R7");
        wr(A_CAUSE, 0);
        exp_rd(A_CAUSE, 0, "R7");

        tick(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule